// File: doc/BRIEF.md
# Overlapped Register Window File

This block is the general-purpose register file of a load/store processor that keeps procedure context in hardware. Every procedure addresses 32 logical registers. The lowest ten are shared by all procedures. The upper 22 come from one of four physical windows arranged in a ring. Consecutive windows share six registers, so a value the caller leaves in its outgoing registers is already in the callee's incoming registers and nothing is copied.

The pipeline pulses a call strobe or a return strobe. The block then rotates a current window pointer and translates the logical numbers on its two read ports and one write port into physical addresses. A second pointer marks the window that may not be entered. A call or return that would step onto it is refused and raises a trap request. The spill or fill handler answers with a done strobe, which moves that boundary and clears the request.

Top module: `rwin_regfile`

## Requirements
- R1: After reset the current pointer and the boundary pointer are both 0, neither trap request is raised, and every register reads as zero.
- R2: Logical registers 0 to 9 address the same ten physical registers whatever the current window is.
- R3: Logical register r from 10 to 31 addresses physical register 10 + ((cwp*16 + r - 10) mod 64). Incoming registers (10 to 15) and private registers (16 to 25) of different windows are therefore distinct.
- R4: The outgoing registers (26 to 31) of window w are the incoming registers (10 to 15) of window (w+1) mod 4, and this includes window 3 feeding window 0.
- R5: A call alone moves the current pointer to (cwp+1) mod 4, and a return alone moves it to (cwp+3) mod 4, in the next cycle. This holds unless the move is refused under R6 or R8.
- R6: A call alone while (cwp+1) mod 4 equals the boundary pointer leaves cwp unchanged and raises ovf_trap_o in the next cycle. The request stays high until spill_done_i.
- R7: spill_done_i alone advances the boundary pointer by one (mod 4) and clears ovf_trap_o in the next cycle.
- R8: A return alone while (cwp+3) mod 4 equals the boundary pointer leaves cwp unchanged and raises unf_trap_o. fill_done_i alone moves the boundary pointer back by one (mod 4) and clears unf_trap_o.
- R9: A call and a return in the same cycle are both ignored: no pointer moves and no trap request is raised.
- R10: A write lands at the clock edge. In the cycle of the write, a read port that resolves to the same physical register returns the incoming write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | Procedure call strobe |
| ret_i | input | 1 | Procedure return strobe |
| spill_done_i | input | 1 | Oldest window has been saved; advance boundary |
| fill_done_i | input | 1 | Window has been restored; move boundary back |
| ra_i | input | 5 | Logical register for read port A |
| rb_i | input | 5 | Logical register for read port B |
| we_i | input | 1 | Write enable |
| wa_i | input | 5 | Logical register to write |
| wd_i | input | 32 | Write data |
| rda_o | output | 32 | Read data, port A |
| rdb_o | output | 32 | Read data, port B |
| cwp_o | output | 2 | Current window pointer |
| swp_o | output | 2 | Window boundary pointer |
| ovf_trap_o | output | 1 | Window overflow (spill) request |
| unf_trap_o | output | 1 | Window underflow (fill) request |

## Verification
The bench drives the ring all the way round. This exposes a translation that forgets the modulo when window 3's outgoing registers meet window 0's incoming registers: the callee would then read stale or out-of-range storage. It also provokes a refused call and a refused return. A design that advances the pointer anyway would corrupt the oldest live window, and a design that drops the request early would lose the trap. It also checks simultaneous call and return, and a read of the register being written in the same cycle, where a missing bypass returns the old value.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
    localparam int NWIN   = 4;
    localparam int NGLOB  = 10;
    localparam int NPAR   = 6;
    localparam int NLOC   = 10;
    localparam int NLOG   = NGLOB + 2 * NPAR + NLOC;
    localparam int STRIDE = NPAR + NLOC;
    localparam int NPHYS  = NGLOB + NWIN * STRIDE;
    localparam int PTR_W  = $clog2(NWIN);
    localparam int LA_W   = $clog2(NLOG);
    localparam int PA_W   = $clog2(NPHYS);

    typedef struct packed {
        logic [PTR_W-1:0] cwp;
        logic [PTR_W-1:0] swp;
        logic             ovf;
        logic             unf;
    } win_ctl_t;
endpackage

// File: rtl/rwin_map.sv
module rwin_map
    import rwin_pkg::*;
#(
    parameter int N_GLOB = NGLOB,
    parameter int N_WIN  = NWIN,
    parameter int STEP   = STRIDE,
    parameter int LAW    = LA_W,
    parameter int PAW    = PA_W,
    parameter int PW     = PTR_W
) (
    input  logic [PW-1:0]  cwp,
    input  logic [LAW-1:0] la,
    output logic [PAW-1:0] pa
);
    localparam int RING = N_WIN * STEP;

    int off;

    always_comb begin
        off = int'(cwp) * STEP + int'(la) - N_GLOB;
        if (int'(la) < N_GLOB) begin
            pa = PAW'(la);
        end else begin
            pa = PAW'(N_GLOB + (off % RING));
        end
    end
endmodule

// File: rtl/rwin_ctrl.sv
module rwin_ctrl
    import rwin_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     call_i,
    input  logic     ret_i,
    input  logic     spill_done_i,
    input  logic     fill_done_i,
    output win_ctl_t ctl
);
    win_ctl_t ctl_d, ctl_q;
    logic [PTR_W-1:0] up_w, dn_w;

    always_comb begin
        ctl_d = ctl_q;
        up_w  = ctl_q.cwp + PTR_W'(1);
        dn_w  = ctl_q.cwp - PTR_W'(1);

        if (call_i && !ret_i) begin
            if (up_w == ctl_q.swp) ctl_d.ovf = 1'b1;
            else                   ctl_d.cwp = up_w;
        end else if (ret_i && !call_i) begin
            if (dn_w == ctl_q.swp) ctl_d.unf = 1'b1;
            else                   ctl_d.cwp = dn_w;
        end

        if (spill_done_i && !fill_done_i) begin
            ctl_d.swp = ctl_q.swp + PTR_W'(1);
            ctl_d.ovf = 1'b0;
        end else if (fill_done_i && !spill_done_i) begin
            ctl_d.swp = ctl_q.swp - PTR_W'(1);
            ctl_d.unf = 1'b0;
        end else if (fill_done_i && spill_done_i) begin
            ctl_d.ovf = 1'b0;
            ctl_d.unf = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ctl = ctl_q;
endmodule

// File: rtl/rwin_store.sv
module rwin_store #(
    parameter int DW    = 32,
    parameter int DEPTH = 74,
    parameter int AW    = 7,
    parameter int NRD   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [AW-1:0]            wpa,
    input  logic [DW-1:0]            wd,
    input  logic [NRD-1:0][AW-1:0]   rpa,
    output logic [NRD-1:0][DW-1:0]   rd
);
    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we && int'(wpa) < DEPTH) mem_d[wpa] = wd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '{default: '0};
        else        mem_q <= mem_d;
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            if (we && rpa[p] == wpa)        rd[p] = wd;
            else if (int'(rpa[p]) < DEPTH)  rd[p] = mem_q[rpa[p]];
            else                            rd[p] = '0;
        end
    end
endmodule

// File: rtl/rwin_regfile.sv
module rwin_regfile
    import rwin_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_i,
    input  logic              ret_i,
    input  logic              spill_done_i,
    input  logic              fill_done_i,
    input  logic [LA_W-1:0]   ra_i,
    input  logic [LA_W-1:0]   rb_i,
    input  logic              we_i,
    input  logic [LA_W-1:0]   wa_i,
    input  logic [DATA_W-1:0] wd_i,
    output logic [DATA_W-1:0] rda_o,
    output logic [DATA_W-1:0] rdb_o,
    output logic [PTR_W-1:0]  cwp_o,
    output logic [PTR_W-1:0]  swp_o,
    output logic              ovf_trap_o,
    output logic              unf_trap_o
);
    localparam int NPORT = 3;

    win_ctl_t                     ctl;
    logic [NPORT-1:0][LA_W-1:0]   la_v;
    logic [NPORT-1:0][PA_W-1:0]   pa_v;
    logic [1:0][PA_W-1:0]         rpa_v;
    logic [1:0][DATA_W-1:0]       rd_v;

    rwin_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .call_i       (call_i),
        .ret_i        (ret_i),
        .spill_done_i (spill_done_i),
        .fill_done_i  (fill_done_i),
        .ctl          (ctl)
    );

    assign la_v = {wa_i, rb_i, ra_i};

    for (genvar i = 0; i < NPORT; i++) begin : g_map
        rwin_map u_map (
            .cwp (ctl.cwp),
            .la  (la_v[i]),
            .pa  (pa_v[i])
        );
    end

    assign rpa_v = {pa_v[1], pa_v[0]};

    rwin_store #(
        .DW    (DATA_W),
        .DEPTH (NPHYS),
        .AW    (PA_W),
        .NRD   (2)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we_i),
        .wpa   (pa_v[2]),
        .wd    (wd_i),
        .rpa   (rpa_v),
        .rd    (rd_v)
    );

    assign rda_o      = rd_v[0];
    assign rdb_o      = rd_v[1];
    assign cwp_o      = ctl.cwp;
    assign swp_o      = ctl.swp;
    assign ovf_trap_o = ctl.ovf;
    assign unf_trap_o = ctl.unf;
endmodule

// File: rtl/rwin_regfile_chk.sv
module rwin_regfile_chk
    import rwin_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              call_i,
    input logic              ret_i,
    input logic              spill_done_i,
    input logic              fill_done_i,
    input logic [LA_W-1:0]   ra_i,
    input logic              we_i,
    input logic [LA_W-1:0]   wa_i,
    input logic [DATA_W-1:0] wd_i,
    input logic [DATA_W-1:0] rda_o,
    input logic [PTR_W-1:0]  cwp_o,
    input logic [PTR_W-1:0]  swp_o,
    input logic              ovf_trap_o,
    input logic              unf_trap_o
);
    logic [PTR_W-1:0] nxt, prv;
    assign nxt = cwp_o + PTR_W'(1);
    assign prv = cwp_o - PTR_W'(1);

    p_call_adv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !ret_i && nxt != swp_o) |=> (cwp_o == $past(nxt)));

    p_ret_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !call_i && prv != swp_o) |=> (cwp_o == $past(prv)));

    p_ovf_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !ret_i && nxt == swp_o) |=> (ovf_trap_o && $stable(cwp_o)));

    p_ovf_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_trap_o && !spill_done_i) |=> ovf_trap_o);

    p_spill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (spill_done_i && !fill_done_i) |=> (!ovf_trap_o && swp_o == $past(swp_o) + PTR_W'(1)));

    p_unf_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !call_i && prv == swp_o) |=> (unf_trap_o && $stable(cwp_o)));

    p_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_done_i && !spill_done_i) |=> (!unf_trap_o && swp_o == $past(swp_o) - PTR_W'(1)));

    p_both_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && ret_i) |=> $stable(cwp_o));

    p_bypass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && ra_i == wa_i) |-> (rda_o == wd_i));
endmodule

bind rwin_regfile rwin_regfile_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .call_i       (call_i),
    .ret_i        (ret_i),
    .spill_done_i (spill_done_i),
    .fill_done_i  (fill_done_i),
    .ra_i         (ra_i),
    .we_i         (we_i),
    .wa_i         (wa_i),
    .wd_i         (wd_i),
    .rda_o        (rda_o),
    .cwp_o        (cwp_o),
    .swp_o        (swp_o),
    .ovf_trap_o   (ovf_trap_o),
    .unf_trap_o   (unf_trap_o)
);

// File: tb/tb_rwin_regfile.sv
`timescale 1ns/1ps
module tb_rwin_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_i = 0, ret_i = 0, spill_done_i = 0, fill_done_i = 0;
    logic [4:0]  ra_i = 0, rb_i = 0, wa_i = 0;
    logic        we_i = 0;
    logic [31:0] wd_i = 0;
    logic [31:0] rda_o, rdb_o;
    logic [1:0]  cwp_o, swp_o;
    logic        ovf_trap_o, unf_trap_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // behavioural reference state
    int unsigned mref [74];
    int mcwp = 0, mswp = 0;
    bit movf = 0, munf = 0;

    always #4 clk = ~clk;

    rwin_regfile dut (
        .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
        .spill_done_i(spill_done_i), .fill_done_i(fill_done_i),
        .ra_i(ra_i), .rb_i(rb_i), .we_i(we_i), .wa_i(wa_i), .wd_i(wd_i),
        .rda_o(rda_o), .rdb_o(rdb_o), .cwp_o(cwp_o), .swp_o(swp_o),
        .ovf_trap_o(ovf_trap_o), .unf_trap_o(unf_trap_o)
    );

    function automatic int where(int r, int w);
        int off;
        if (r < 10) return r;
        off = (r - 10) + 16 * w;
        while (off >= 64) off -= 64;
        return 10 + off;
    endfunction

    task automatic chk(string tag, string sig, longint got, longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0h expected %0h", tag, sig, got, exp);
        end
    endtask

    // inputs already set; compare, clock, update model, clear strobes
    task automatic cyc(string tag);
        int pa, pb, pw;
        int unsigned ea, eb;
        #2;
        pa = where(int'(ra_i), mcwp);
        pb = where(int'(rb_i), mcwp);
        pw = where(int'(wa_i), mcwp);
        ea = (we_i && pw == pa) ? wd_i : mref[pa];
        eb = (we_i && pw == pb) ? wd_i : mref[pb];
        chk(tag, "rda", rda_o, ea);
        chk(tag, "rdb", rdb_o, eb);
        chk(tag, "cwp", cwp_o, mcwp);
        chk(tag, "swp", swp_o, mswp);
        chk(tag, "ovf", ovf_trap_o, movf);
        chk(tag, "unf", unf_trap_o, munf);
        @(posedge clk);
        if (we_i) mref[pw] = wd_i;
        if (call_i && !ret_i) begin
            if ((mcwp + 1) % 4 == mswp) movf = 1; else mcwp = (mcwp + 1) % 4;
        end else if (ret_i && !call_i) begin
            if ((mcwp + 3) % 4 == mswp) munf = 1; else mcwp = (mcwp + 3) % 4;
        end
        if (spill_done_i && !fill_done_i) begin
            mswp = (mswp + 1) % 4; movf = 0;
        end else if (fill_done_i && !spill_done_i) begin
            mswp = (mswp + 3) % 4; munf = 0;
        end else if (fill_done_i && spill_done_i) begin
            movf = 0; munf = 0;
        end
        @(negedge clk);
        call_i = 0; ret_i = 0; spill_done_i = 0; fill_done_i = 0; we_i = 0;
    endtask

    task automatic wr(string tag, int r, int unsigned v);
        we_i = 1; wa_i = 5'(r); wd_i = v; ra_i = 5'(r); rb_i = 5'(r);
        cyc(tag);
    endtask

    task automatic rd2(string tag, int a, int b);
        ra_i = 5'(a); rb_i = 5'(b);
        cyc(tag);
    endtask

    initial begin
        foreach (mref[i]) mref[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        rd2("R1", 0, 31);
        rd2("R1", 15, 20);

        // R2: globals shared by all windows
        for (int i = 0; i < 10; i++) wr("R2", i, 32'hA0 + i);
        call_i = 1; cyc("R5");
        for (int i = 0; i < 10; i++) rd2("R2", i, 9 - i);

        // R3: private registers distinct per window
        for (int i = 16; i < 26; i++) wr("R3", i, 32'h100 + i);
        call_i = 1; cyc("R5");
        for (int i = 16; i < 26; i++) wr("R3", i, 32'h500 + i);
        ret_i = 1; cyc("R5");
        for (int i = 16; i < 26; i += 2) rd2("R3", i, i + 1);
        for (int i = 10; i < 16; i++) wr("R3", i, 32'h700 + i);

        // R4: outgoing of window 1 appear as incoming of window 2
        for (int i = 26; i < 32; i++) wr("R4", i, 32'h200 + i);
        call_i = 1; cyc("R5");
        for (int i = 10; i < 16; i++) rd2("R4", i, 41 - i);
        call_i = 1; cyc("R5");
        for (int i = 26; i < 32; i++) wr("R4", i, 32'h300 + i);

        // R6: call onto boundary is refused
        call_i = 1; cyc("R6");
        rd2("R6", 0, 0);
        rd2("R6", 1, 1);
        // R7: spill done moves boundary
        spill_done_i = 1; cyc("R7");
        call_i = 1; cyc("R5");
        // R4: window 3 outgoing wrap to window 0 incoming
        for (int i = 10; i < 16; i++) rd2("R4", i, i);

        // R8: returns down to the boundary
        ret_i = 1; cyc("R5");
        ret_i = 1; cyc("R5");
        ret_i = 1; cyc("R8");
        rd2("R8", 12, 20);
        fill_done_i = 1; cyc("R8");
        ret_i = 1; cyc("R8");
        rd2("R8", 16, 31);

        // R9: simultaneous call and return
        call_i = 1; ret_i = 1; cyc("R9");
        rd2("R9", 0, 10);
        call_i = 1; ret_i = 1; rd2("R9", 16, 26);

        // R10: write-first bypass, then stored value
        wr("R10", 12, 32'hDEADBEEF);
        rd2("R10", 12, 12);
        we_i = 1; wa_i = 5'd3; wd_i = 32'h12345678; ra_i = 5'd3; rb_i = 5'd4;
        cyc("R10");
        rd2("R10", 3, 4);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule